// File: doc/BRIEF.md
# Link Rate and Lane Count Selector

This block picks the transmit configuration for a serial display link. A single start pulse provides the required pixel clock, the colour depth, and the sink's limits on rate and lane count. The block then walks the candidate configurations one per clock, slowest rate first. Within a rate it tries one, two and then four lanes. It stops at the first configuration whose payload capacity covers the pixel stream.

When it finishes it raises a one-cycle done pulse and presents four results, which hold until the next search completes:

- the chosen lane count;
- the chosen rate in kHz;
- a fail flag;
- a mode-valid verdict.

A bridge input pins the search to the middle rate. A capability input tells the block whether the sink speaks protocol revision 1.2. Without that capability the top rate is rejected as a mode, even though the search may still pick it.

Top module: `lnk_cfg_sel`

## Requirements
- R1: After reset, done_o, busy_o, fail_o and valid_o are 0, and lanes_o and rate_o are 0.
- R2: Bits per pixel are 24 when bpc_i is 0. Otherwise bits per pixel are three times bpc_i.
- R3: Candidates are visited rate-major. The rates are 162000, 270000 and 540000 kHz in that order. Within each rate, lanes are tried as 1, 2 and 4. A candidate is legal only when its lanes do not exceed max_lanes_i and its rate does not exceed max_rate_i. The first legal candidate that fits is chosen, so lanes_o is always 0, 1, 2 or 4.
- R4: A candidate fits when lanes × rate × 8 ≥ pix_clk_i × bits per pixel. Equality counts as a fit.
- R5: With bridge_i set, only rate 270000 is tried, with lanes 1, 2 and 4. The max_rate_i limit does not apply in this mode.
- R6: If no candidate fits, the block reports lanes_o = 0, rate_o = 0, fail_o = 1 and valid_o = 0.
- R7: valid_o is 1 only when the search succeeds, and it is 0 if the chosen rate is 540000 while v12_cap_i was 0 at start.
- R8: One candidate slot is evaluated per clock. There are nine slots, or three with bridge_i set, and illegal slots still take a clock. If start_i is sampled at edge P0 and the chosen slot is the k-th (counting from 1), then done_o is high for exactly the one cycle after edge Pk. busy_o is high from P0 until that edge. A failed search finishes after the last slot.
- R9: lanes_o, rate_o, fail_o and valid_o change only at the edge that raises done_o. A start_i pulse while busy_o is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a search; the other inputs are captured on this edge |
| pix_clk_i | input | PCLK_W | Required pixel clock in kHz |
| bpc_i | input | BPC_W | Bits per colour component; 0 selects the default |
| max_rate_i | input | RATE_W (20) | Highest rate the sink accepts, in kHz |
| max_lanes_i | input | LANE_W (3) | Highest lane count the sink accepts |
| bridge_i | input | 1 | Restricts the search to the 270000 kHz rate |
| v12_cap_i | input | 1 | Sink supports protocol revision 1.2 |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle pulse at the end of a search |
| lanes_o | output | LANE_W (3) | Chosen lane count, 0 on failure |
| rate_o | output | RATE_W (20) | Chosen rate in kHz, 0 on failure |
| fail_o | output | 1 | No candidate fits |
| valid_o | output | 1 | Mode is usable on this sink |

## Verification
The assertions assume that start_i is a short pulse. They also assume that a search is only expected to begin when start_i arrives with busy_o low, and the hold property relies on this. The bench drives start_i for exactly one cycle, from the falling edge, while the block is idle. The only exception is one deliberate pulse during a search, which tests that such a pulse is ignored. The bench keeps bpc_i at or below its field range and max_lanes_i within 0 to 7, so bits per pixel never exceed the comparator width. Its stimulus includes exact-equality capacity points, limits that sit between table rates, and sinks that advertise zero lanes.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
  localparam int NUM_RATES   = 3;
  localparam int LANE_STEPS  = 3;
  localparam int RATE_W      = 20;
  localparam int LANE_W      = LANE_STEPS;
  localparam int RIDX_W      = $clog2(NUM_RATES);
  localparam int LSH_W       = $clog2(LANE_STEPS);
  localparam int BRIDGE_RIDX = 1;
  localparam int TOP_RATE    = 540000;

  typedef enum logic {ST_IDLE, ST_SRCH} lcs_state_e;

  function automatic logic [RATE_W-1:0] rate_khz(input logic [RIDX_W-1:0] idx);
    case (idx)
      2'd0:    rate_khz = RATE_W'(162000);
      2'd1:    rate_khz = RATE_W'(270000);
      default: rate_khz = RATE_W'(540000);
    endcase
  endfunction
endpackage

// File: rtl/lcs_cand_seq.sv
module lcs_cand_seq
  import lcs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              bridge_i,
  output logic [RIDX_W-1:0] rate_idx_o,
  output logic [LSH_W-1:0]  lane_sh_o,
  output logic              last_o
);
  logic lane_wrap;
  assign lane_wrap = (lane_sh_o == LSH_W'(LANE_STEPS-1));
  assign last_o    = lane_wrap && (bridge_i || rate_idx_o == RIDX_W'(NUM_RATES-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_idx_o <= '0;
      lane_sh_o  <= '0;
    end else if (load_i) begin
      rate_idx_o <= bridge_i ? RIDX_W'(BRIDGE_RIDX) : '0;
      lane_sh_o  <= '0;
    end else if (step_i) begin
      if (lane_wrap) begin
        lane_sh_o  <= '0;
        rate_idx_o <= rate_idx_o + 1'b1;
      end else begin
        lane_sh_o <= lane_sh_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lcs_fit_cmp.sv
module lcs_fit_cmp
  import lcs_pkg::*;
#(
  parameter int PCLK_W = 20,
  parameter int BPP_W  = 6
) (
  input  logic [LANE_W-1:0] lanes_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [PCLK_W-1:0] pix_i,
  input  logic [BPP_W-1:0]  bpp_i,
  output logic              fit_o
);
  localparam int SUP_W = RATE_W + LANE_W + 3;
  localparam int DEM_W = PCLK_W + BPP_W;
  localparam int CMP_W = ((SUP_W > DEM_W) ? SUP_W : DEM_W) + 1;

  logic [CMP_W-1:0] supply, demand;
  // multiply-compare instead of dividing capacity by bpp
  assign supply = (CMP_W'(lanes_i) * CMP_W'(rate_i)) << 3;
  assign demand = CMP_W'(pix_i) * CMP_W'(bpp_i);
  assign fit_o  = (supply >= demand);
endmodule

// File: rtl/lnk_cfg_sel.sv
module lnk_cfg_sel
  import lcs_pkg::*;
#(
  parameter int PCLK_W = 20,
  parameter int BPC_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [PCLK_W-1:0] pix_clk_i,
  input  logic [BPC_W-1:0]  bpc_i,
  input  logic [RATE_W-1:0] max_rate_i,
  input  logic [LANE_W-1:0] max_lanes_i,
  input  logic              bridge_i,
  input  logic              v12_cap_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [LANE_W-1:0] lanes_o,
  output logic [RATE_W-1:0] rate_o,
  output logic              fail_o,
  output logic              valid_o
);
  localparam int BPP_W = BPC_W + 2;

  lcs_state_e        state_q;
  logic [PCLK_W-1:0] pix_q;
  logic [BPP_W-1:0]  bpp_q;
  logic [RATE_W-1:0] maxr_q;
  logic [LANE_W-1:0] maxl_q;
  logic              bridge_q, v12_q;

  logic [RIDX_W-1:0] rate_idx;
  logic [LSH_W-1:0]  lane_sh;
  logic              last, fit, legal, accept, load, step;
  logic [LANE_W-1:0] cand_lanes;
  logic [RATE_W-1:0] cand_rate;

  assign load = (state_q == ST_IDLE) && start_i;
  assign step = (state_q == ST_SRCH) && !accept;

  lcs_cand_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .step_i     (step),
    .bridge_i   (load ? bridge_i : bridge_q),
    .rate_idx_o (rate_idx),
    .lane_sh_o  (lane_sh),
    .last_o     (last)
  );

  assign cand_lanes = LANE_W'(1) << lane_sh;
  assign cand_rate  = rate_khz(rate_idx);

  lcs_fit_cmp #(.PCLK_W(PCLK_W), .BPP_W(BPP_W)) u_cmp (
    .lanes_i (cand_lanes),
    .rate_i  (cand_rate),
    .pix_i   (pix_q),
    .bpp_i   (bpp_q),
    .fit_o   (fit)
  );

  // bridge mode ignores the sink rate limit
  assign legal  = (cand_lanes <= maxl_q) && (bridge_q || cand_rate <= maxr_q);
  assign accept = legal && fit;
  assign busy_o = (state_q == ST_SRCH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      pix_q    <= '0;
      bpp_q    <= '0;
      maxr_q   <= '0;
      maxl_q   <= '0;
      bridge_q <= 1'b0;
      v12_q    <= 1'b0;
      done_o   <= 1'b0;
      lanes_o  <= '0;
      rate_o   <= '0;
      fail_o   <= 1'b0;
      valid_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (load) begin
        state_q  <= ST_SRCH;
        pix_q    <= pix_clk_i;
        bpp_q    <= (bpc_i == '0) ? BPP_W'(24) : BPP_W'(bpc_i) * BPP_W'(3);
        maxr_q   <= max_rate_i;
        maxl_q   <= max_lanes_i;
        bridge_q <= bridge_i;
        v12_q    <= v12_cap_i;
      end else if (state_q == ST_SRCH) begin
        if (accept) begin
          state_q <= ST_IDLE;
          done_o  <= 1'b1;
          lanes_o <= cand_lanes;
          rate_o  <= cand_rate;
          fail_o  <= 1'b0;
          valid_o <= !(cand_rate == RATE_W'(TOP_RATE) && !v12_q);
        end else if (last) begin
          state_q <= ST_IDLE;
          done_o  <= 1'b1;
          lanes_o <= '0;
          rate_o  <= '0;
          fail_o  <= 1'b1;
          valid_o <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/lnk_cfg_sel_chk.sv
module lnk_cfg_sel_chk
  import lcs_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [LANE_W-1:0] lanes_o,
  input logic [RATE_W-1:0] rate_o,
  input logic              fail_o,
  input logic              valid_o
);
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  busy_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R8
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (busy_o || done_o));
  // R6
  fail_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (lanes_o == '0 && rate_o == '0 && !valid_o));
  // R7
  valid_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !fail_o && lanes_o != '0);
  // R3
  lanes_pow2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lanes_o));
  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(lanes_o) && $stable(rate_o) &&
                               $stable(fail_o) && $stable(valid_o) && !done_o));
endmodule

bind lnk_cfg_sel lnk_cfg_sel_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .lanes_o (lanes_o),
  .rate_o  (rate_o),
  .fail_o  (fail_o),
  .valid_o (valid_o)
);

// File: tb/tb_lnk_cfg_sel.sv
module tb_lnk_cfg_sel;
  localparam int CLK_PERIOD = 10;
  localparam int PCLK_W = 20;
  localparam int BPC_W  = 4;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [PCLK_W-1:0] pix_clk_i = '0;
  logic [BPC_W-1:0]  bpc_i = '0;
  logic [19:0]       max_rate_i = '0;
  logic [2:0]        max_lanes_i = '0;
  logic              bridge_i = 1'b0, v12_cap_i = 1'b0;
  logic              busy_o, done_o, fail_o, valid_o;
  logic [2:0]        lanes_o;
  logic [19:0]       rate_o;

  int checks = 0;
  int errors = 0;
  int e_lanes = 0, e_rate = 0, e_fail = 0, e_valid = 0;
  bit hold_on = 1'b0;

  lnk_cfg_sel #(.PCLK_W(PCLK_W), .BPC_W(BPC_W)) dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R9: compare held outputs against the model on every idle clock
  always @(negedge clk_i) begin
    if (hold_on && rst_ni && !busy_o && !done_o) begin
      chk(lanes_o == e_lanes && rate_o == e_rate && fail_o == e_fail && valid_o == e_valid,
          "R9 hold", {lanes_o, rate_o, fail_o, valid_o},
          {e_lanes[2:0], e_rate[19:0], e_fail[0], e_valid[0]});
    end
  end

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk_i);
      wd++;
      if (wd > 20000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", wd, 20000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  // behavioural model: returns expected results and slot count
  task automatic model(input longint pix, input int bpc, input longint maxr, input int maxl,
                       input bit br, input bit v12,
                       output int lanes, output int rate, output int fail, output int valid,
                       output int n);
    longint rates[$] = '{162000, 270000, 540000};
    int ln[$] = '{1, 2, 4};
    longint bpp = (bpc == 0) ? 24 : 3 * bpc;
    int pos = 0;
    lanes = 0; rate = 0; fail = 1; valid = 0;
    n = br ? 3 : 9;
    foreach (rates[i]) begin
      if (br && rates[i] != 270000) continue;
      foreach (ln[j]) begin
        pos++;
        if (fail && ln[j] <= maxl && (br || rates[i] <= maxr) &&
            ln[j] * rates[i] * 8 >= pix * bpp) begin
          lanes = ln[j]; rate = int'(rates[i]); fail = 0; n = pos;
          valid = (rates[i] == 540000 && !v12) ? 0 : 1;
        end
      end
    end
  endtask

  task automatic run(input int pix, input int bpc, input int maxr, input int maxl,
                     input bit br, input bit v12, input string tag, input bit poke);
    int xl, xr, xf, xv, n;
    bit seen = 1'b0;
    model(pix, bpc, maxr, maxl, br, v12, xl, xr, xf, xv, n);
    @(negedge clk_i);
    start_i = 1'b1; pix_clk_i = PCLK_W'(pix); bpc_i = BPC_W'(bpc);
    max_rate_i = 20'(maxr); max_lanes_i = 3'(maxl); bridge_i = br; v12_cap_i = v12;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int c = 1; c <= 12 && !seen; c++) begin
      if (poke && c == 1) begin
        start_i = 1'b1; pix_clk_i = '0; bpc_i = '0; max_lanes_i = 3'd4;
        max_rate_i = 20'd540000; bridge_i = 1'b0;
      end
      @(negedge clk_i);
      start_i = 1'b0;
      if (c < n) begin
        chk(busy_o && !done_o, "R8 busy", {busy_o, done_o}, 2);
      end else begin
        seen = 1'b1;
        chk(done_o && !busy_o, "R8 done timing", {done_o, busy_o}, 2);
        e_lanes = xl; e_rate = xr; e_fail = xf; e_valid = xv;
        chk(lanes_o == xl, {tag, " lanes"}, lanes_o, xl);
        chk(rate_o == xr, {tag, " rate"}, rate_o, xr);
        chk(fail_o == xf, {tag, " R6 fail"}, fail_o, xf);
        chk(valid_o == xv, {tag, " R7 valid"}, valid_o, xv);
      end
    end
    if (poke) begin
      repeat (3) begin
        @(negedge clk_i);
        chk(!done_o && !busy_o, "R9 start while busy ignored", {done_o, busy_o}, 0);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(!done_o && !busy_o && !fail_o && !valid_o && lanes_o == 0 && rate_o == 0,
        "R1 reset", {done_o, busy_o, fail_o, valid_o, lanes_o, rate_o}, 0);
    rst_ni = 1'b1;
    hold_on = 1'b1;
    @(negedge clk_i);
    run(54000, 0, 540000, 4, 0, 1, "R4 equality", 0);
    run(54001, 0, 540000, 4, 0, 1, "R4 just over", 0);
    run(54000, 8, 540000, 4, 0, 1, "R2 bpc8", 0);
    run(72000, 6, 540000, 4, 0, 1, "R2 bpc6", 0);
    run(43200, 10, 540000, 4, 0, 1, "R2 bpc10", 0);
    run(216001, 0, 540000, 4, 0, 1, "R3 rate-major", 0);
    run(100000, 0, 162000, 2, 0, 1, "R3 lane limit", 0);
    run(100000, 0, 540000, 1, 0, 1, "R3 one lane", 0);
    run(300000, 0, 269999, 4, 0, 1, "R3 rate limit", 0);
    run(400000, 0, 270000, 4, 0, 1, "R6 fail rate cap", 0);
    run(1000, 0, 540000, 0, 0, 1, "R6 zero lanes", 0);
    run(500000, 10, 540000, 4, 0, 0, "R7 top rate no v12", 0);
    run(500000, 10, 540000, 4, 0, 1, "R7 top rate v12", 0);
    run(200000, 8, 162000, 4, 1, 1, "R5 bridge", 0);
    run(80000, 8, 540000, 4, 1, 1, "R5 bridge one lane", 0);
    run(400000, 8, 540000, 4, 1, 1, "R5 bridge fail", 0);
    run(700000, 0, 540000, 4, 0, 1, "R9 poke", 1);
    for (int i = 0; i < 40; i++) begin
      int rs[$] = '{162000, 200000, 270000, 540000, 600000};
      run(int'($urandom_range(0, 800000)), int'($urandom_range(0, 12)),
          rs[$urandom_range(0, 4)], int'($urandom_range(0, 5)),
          1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 1)), "R3 R4 random", 0);
    end
    repeat (4) @(negedge clk_i);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule